// File: doc/BRIEF.md
# Boot Option Configuration Loader

This block sits between the reset input and the processor core of a small controller. When reset is released, the block reads a fixed 256-byte configuration area at the top of the 16-bit program space, one byte per clock. It turns a handful of those bytes into latched pad options: the output form of each bit of ports 0, 1 and 3, the nibble pull-ups of port 0 and the pull-ups of port 7. The core is held stalled until a hold-off window has elapsed and every byte has been consumed. The block then raises a run enable, and the core starts fetching from address 0.

The sequencer is a five-state machine. ST_IDLE is the reset state and always moves to ST_FETCH on the first clock. ST_FETCH issues one read per cycle and moves to ST_LAST after the final address. ST_LAST waits for the final byte to return. From there it goes to ST_RUN if the hold-off timer has already expired, and to ST_HOLD otherwise. ST_HOLD moves to ST_RUN when the timer expires. ST_RUN is terminal until the next reset. Reset is asynchronous and active low. Asserting it at any time returns every option to the safe setting (open drain, no pull-up) and restarts the whole sequence.

The hold-off timer starts counting system clocks at reset release, and its length is a parameter. The default length is three milliseconds at the configured clock rate in kHz. Because the run enable waits for both the timer and the read sequence, a short hold-off can never cut the loading short.

Top module: `opt_boot_loader`

## Requirements
- R1: While rst_n is low, cpu_run, load_done and mem_rd are 0, and all option outputs are 0: every port bit is open drain, with no pull-up.
- R2: After reset release, mem_rd is high for exactly 256 consecutive cycles, beginning after the first rising edge. mem_addr steps through FF00h to FFFFh in ascending order, one address per cycle. Read data is taken in the cycle after its address.
- R3: Bit i of byte FF00h sets p0_cmos[i]; bit i of byte FF01h sets p1_cmos[i]; bits 3:0 of byte FF02h set p3_cmos[3:0]. A value of 1 means CMOS output and 0 means open drain.
- R4: Bit 0 of byte FF03h enables the pull-ups of port 0 bits 3:0, and bit 1 enables those of bits 7:4. p0_pullup[i] is high only when its nibble is enabled and p0_cmos[i] is 1, so an open-drain bit never has a pull-up.
- R5: Bits 3:0 of byte FF04h set p7_pullup[3:0]. p7_pullup[5:4] are always 0. All other bits of bytes FF02h to FF04h, and all other bytes of the area, have no effect on any output.
- R6: load_done rises at rising edge 258 after reset release. From then until the next reset, all option outputs stay constant, whatever the memory returns.
- R7: cpu_run rises at rising edge max(HOLD_CYCLES+1, 258) after reset release and then stays high until reset. mem_rd stays low while cpu_run is high.
- R8: Asserting reset during loading or after the run enable clears all options, load_done and cpu_run at once. After release, the sequence restarts from FF00h and the options take the new memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_rd | output | 1 | Read strobe to program memory |
| mem_addr | output | 16 | Program memory read address (0 when idle) |
| mem_data | input | 8 | Read data, valid one cycle after the address |
| cpu_run | output | 1 | Run enable for the core |
| load_done | output | 1 | All option bytes latched |
| p0_cmos | output | 8 | Port 0 output form per bit (1 = CMOS) |
| p0_pullup | output | 8 | Port 0 effective pull-up enable per bit |
| p1_cmos | output | 8 | Port 1 output form per bit (1 = CMOS) |
| p3_cmos | output | 4 | Port 3 output form per bit (1 = CMOS) |
| p7_pullup | output | 6 | Port 7 pull-up enable per bit |

## Verification
The option bytes are tried in several patterns, and each pattern separates a different kind of fault. All zeros and all ones show the two extremes. Alternating patterns such as A5h and 5Ah catch swapped or shifted bits. Patterns that enable only one port 0 nibble show whether each nibble enable lands on the right four bits. Patterns that enable a pull-up on an open-drain bit show whether the forcing rule holds. The unused upper bits of bytes FF02h to FF04h, and every byte after FF04h, are filled with nonzero data, so that decoding of the wrong byte or bit shows up at the option outputs. Two instances with a long and a short hold-off tell apart a run enable driven by the timer from one driven by the end of reading. Reset applied in mid-load and after the run enable, with the memory contents changed between boots, shows that the sequence fully restarts.

// File: rtl/opt_boot_pkg.sv
package opt_boot_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LAST,
        ST_HOLD,
        ST_RUN
    } boot_state_e;

    // Byte offsets inside the option area that carry meaning
    localparam int OFS_P0_FORM = 0;
    localparam int OFS_P1_FORM = 1;
    localparam int OFS_P3_FORM = 2;
    localparam int OFS_P0_PULL = 3;
    localparam int OFS_P7_PULL = 4;

    localparam int P0_W     = 8;
    localparam int P1_W     = 8;
    localparam int P3_W     = 4;
    localparam int P7_W     = 6;
    localparam int P7_PU_W  = 4;
    localparam int NIB_W    = 4;
    localparam int P0_NIBS  = P0_W / NIB_W;

    typedef struct packed {
        logic [P0_W-1:0]    p0_form;
        logic [P1_W-1:0]    p1_form;
        logic [P3_W-1:0]    p3_form;
        logic [P0_NIBS-1:0] p0_nib_pu;
        logic [P7_PU_W-1:0] p7_pu;
    } opt_regs_t;

endpackage

// File: rtl/opt_hold_timer.sv
module opt_hold_timer #(
    parameter int HOLD_CYCLES = 18000
) (
    input  logic clk,
    input  logic rst_n,
    output logic expired_o
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYCLES);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = (cnt_q == LIMIT);

    // R7
    hold_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expired_o |=> expired_o);

    // R7
    hold_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT);

endmodule

// File: rtl/opt_seq.sv
module opt_seq
    import opt_boot_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int AREA_BASE  = 32'hFF00,
    parameter int AREA_BYTES = 256
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          hold_done_i,
    output logic                          mem_rd_o,
    output logic [ADDR_W-1:0]             mem_addr_o,
    output logic                          cap_vld_o,
    output logic [$clog2(AREA_BYTES)-1:0] cap_ofs_o,
    output logic                          done_o,
    output logic                          run_o
);
    localparam int OFS_W = $clog2(AREA_BYTES);
    localparam logic [OFS_W-1:0] LAST_OFS = OFS_W'(AREA_BYTES - 1);
    localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(AREA_BASE);

    boot_state_e state_q, state_d;
    logic [OFS_W-1:0] idx_q;
    logic [OFS_W-1:0] cap_ofs_q;
    logic             cap_vld_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = ST_FETCH;
            ST_FETCH: if (idx_q == LAST_OFS) state_d = ST_LAST;
            ST_LAST:  state_d = hold_done_i ? ST_RUN : ST_HOLD;
            ST_HOLD:  if (hold_done_i) state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Read index and capture pipeline (one-cycle memory latency)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q     <= '0;
            cap_vld_q <= 1'b0;
            cap_ofs_q <= '0;
        end else begin
            cap_vld_q <= (state_q == ST_FETCH);
            cap_ofs_q <= idx_q;
            if (state_q == ST_FETCH) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        mem_rd_o   = 1'b0;
        mem_addr_o = '0;
        done_o     = 1'b0;
        run_o      = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_FETCH: begin
                mem_rd_o   = 1'b1;
                mem_addr_o = BASE_A + ADDR_W'(idx_q);
            end
            ST_LAST:  ;
            ST_HOLD:  done_o = 1'b1;
            ST_RUN: begin
                done_o = 1'b1;
                run_o  = 1'b1;
            end
            default:  ;
        endcase
    end

    assign cap_vld_o = cap_vld_q;
    assign cap_ofs_o = cap_ofs_q;

    // R2
    rd_in_area_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |-> (mem_addr_o >= BASE_A));

    // R2
    rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && $past(mem_rd_o)) |-> (mem_addr_o == $past(mem_addr_o) + 1'b1));

    // R2
    cap_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |=> cap_vld_o);

    // R7
    run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_o |=> run_o);

    // R7
    run_needs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_o |-> hold_done_i);

endmodule

// File: rtl/opt_latch.sv
module opt_latch
    import opt_boot_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OFS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [OFS_W-1:0]  wr_ofs_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output opt_regs_t         regs_o
);
    opt_regs_t regs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else if (wr_en_i) begin
            if (wr_ofs_i == OFS_W'(OFS_P0_FORM)) regs_q.p0_form   <= wr_data_i[P0_W-1:0];
            if (wr_ofs_i == OFS_W'(OFS_P1_FORM)) regs_q.p1_form   <= wr_data_i[P1_W-1:0];
            if (wr_ofs_i == OFS_W'(OFS_P3_FORM)) regs_q.p3_form   <= wr_data_i[P3_W-1:0];
            if (wr_ofs_i == OFS_W'(OFS_P0_PULL)) regs_q.p0_nib_pu <= wr_data_i[P0_NIBS-1:0];
            if (wr_ofs_i == OFS_W'(OFS_P7_PULL)) regs_q.p7_pu     <= wr_data_i[P7_PU_W-1:0];
        end
    end

    assign regs_o = regs_q;

    // R6
    regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(regs_q));

endmodule

// File: rtl/opt_pad_map.sv
module opt_pad_map
    import opt_boot_pkg::*;
(
    input  opt_regs_t        regs_i,
    output logic [P0_W-1:0]  p0_cmos_o,
    output logic [P0_W-1:0]  p0_pull_o,
    output logic [P1_W-1:0]  p1_cmos_o,
    output logic [P3_W-1:0]  p3_cmos_o,
    output logic [P7_W-1:0]  p7_pull_o
);
    assign p0_cmos_o = regs_i.p0_form;
    assign p1_cmos_o = regs_i.p1_form;
    assign p3_cmos_o = regs_i.p3_form;

    // Open-drain bits lose their pull-up regardless of the nibble enable
    for (genvar i = 0; i < P0_W; i++) begin : g_p0
        assign p0_pull_o[i] = regs_i.p0_nib_pu[i / NIB_W] & regs_i.p0_form[i];
    end

    for (genvar j = 0; j < P7_W; j++) begin : g_p7
        if (j < P7_PU_W) begin : g_opt
            assign p7_pull_o[j] = regs_i.p7_pu[j];
        end else begin : g_none
            assign p7_pull_o[j] = 1'b0;
        end
    end

endmodule

// File: rtl/opt_boot_loader.sv
module opt_boot_loader
    import opt_boot_pkg::*;
#(
    parameter int CLK_KHZ     = 6000,
    parameter int HOLD_CYCLES = CLK_KHZ * 3,
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int AREA_BASE   = 32'hFF00,
    parameter int AREA_BYTES  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_data,
    output logic              cpu_run,
    output logic              load_done,
    output logic [7:0]        p0_cmos,
    output logic [7:0]        p0_pullup,
    output logic [7:0]        p1_cmos,
    output logic [3:0]        p3_cmos,
    output logic [5:0]        p7_pullup
);
    localparam int OFS_W = $clog2(AREA_BYTES);

    logic             hold_done;
    logic             cap_vld;
    logic [OFS_W-1:0] cap_ofs;
    opt_regs_t        regs;

    opt_hold_timer #(
        .HOLD_CYCLES (HOLD_CYCLES)
    ) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .expired_o (hold_done)
    );

    opt_seq #(
        .ADDR_W     (ADDR_W),
        .AREA_BASE  (AREA_BASE),
        .AREA_BYTES (AREA_BYTES)
    ) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold_done_i (hold_done),
        .mem_rd_o    (mem_rd),
        .mem_addr_o  (mem_addr),
        .cap_vld_o   (cap_vld),
        .cap_ofs_o   (cap_ofs),
        .done_o      (load_done),
        .run_o       (cpu_run)
    );

    opt_latch #(
        .DATA_W (DATA_W),
        .OFS_W  (OFS_W)
    ) i_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (cap_vld),
        .wr_ofs_i  (cap_ofs),
        .wr_data_i (mem_data),
        .regs_o    (regs)
    );

    opt_pad_map i_map (
        .regs_i    (regs),
        .p0_cmos_o (p0_cmos),
        .p0_pull_o (p0_pullup),
        .p1_cmos_o (p1_cmos),
        .p3_cmos_o (p3_cmos),
        .p7_pull_o (p7_pullup)
    );

    // R4
    od_no_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_pullup & ~p0_cmos) == 8'h00);

    // R5
    p7_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        p7_pullup[5:4] == 2'b00);

    // R6
    opts_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_done && $past(load_done)) |->
            $stable({p0_cmos, p0_pullup, p1_cmos, p3_cmos, p7_pullup}));

    // R6
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> load_done);

    // R7
    run_quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_run |-> (!mem_rd && load_done));

endmodule

// File: tb/test_opt_boot_loader.sv
`timescale 1ns/1ps
module test_opt_boot_loader;

    localparam int HOLD_LONG  = 300;
    localparam int HOLD_SHORT = 20;
    localparam int DONE_EDGE  = 258;
    localparam int RUN_LONG   = HOLD_LONG + 1;
    localparam int RUN_SHORT  = 258;

    typedef struct packed {
        logic [7:0] b0, b1, b2, b3, b4;
        logic [7:0] e_p0c, e_p0p, e_p1c;
        logic [3:0] e_p3c;
        logic [5:0] e_p7p;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 8'h00, 8'h00, 8'h03, 8'h0F, 8'h00, 8'h00, 8'h00, 4'h0, 6'h0F},
        '{8'hFF, 8'hFF, 8'h0F, 8'h03, 8'h0F, 8'hFF, 8'hFF, 8'hFF, 4'hF, 6'h0F},
        '{8'hA5, 8'h3C, 8'hF6, 8'h01, 8'h0A, 8'hA5, 8'h05, 8'h3C, 4'h6, 6'h0A},
        '{8'h5A, 8'hC3, 8'h09, 8'h02, 8'hF5, 8'h5A, 8'h50, 8'hC3, 4'h9, 6'h05},
        '{8'hF0, 8'h01, 8'hF0, 8'hFC, 8'h30, 8'hF0, 8'h00, 8'h01, 4'h0, 6'h00},
        '{8'h0F, 8'h80, 8'h03, 8'hFF, 8'hFF, 8'h0F, 8'h0F, 8'h80, 4'h3, 6'h0F}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_rd, mem_rd2;
    logic [15:0] mem_addr, mem_addr2;
    logic [7:0]  mem_data = '0, mem_data2 = '0;
    logic        cpu_run, cpu_run2, load_done, load_done2;
    logic [7:0]  p0_cmos, p0_pullup, p1_cmos, p0_cmos2, p0_pullup2, p1_cmos2;
    logic [3:0]  p3_cmos, p3_cmos2;
    logic [5:0]  p7_pullup, p7_pullup2;
    logic [7:0]  rom [256];

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    always_ff @(posedge clk) begin
        if (mem_rd)  mem_data  <= rom[mem_addr[7:0]];
        if (mem_rd2) mem_data2 <= rom[mem_addr2[7:0]];
    end

    opt_boot_loader #(.HOLD_CYCLES(HOLD_LONG)) i_opt_boot_loader (
        .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_data(mem_data), .cpu_run(cpu_run), .load_done(load_done),
        .p0_cmos(p0_cmos), .p0_pullup(p0_pullup), .p1_cmos(p1_cmos),
        .p3_cmos(p3_cmos), .p7_pullup(p7_pullup)
    );

    opt_boot_loader #(.HOLD_CYCLES(HOLD_SHORT)) i_opt_boot_loader_short (
        .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd2), .mem_addr(mem_addr2),
        .mem_data(mem_data2), .cpu_run(cpu_run2), .load_done(load_done2),
        .p0_cmos(p0_cmos2), .p0_pullup(p0_pullup2), .p1_cmos(p1_cmos2),
        .p3_cmos(p3_cmos2), .p7_pullup(p7_pullup2)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    task automatic fill_rom(input vec_t v, input logic [7:0] salt);
        for (int a = 0; a < 256; a++) rom[a] = 8'hFF ^ 8'(a) ^ salt;
        rom[0] = v.b0; rom[1] = v.b1; rom[2] = v.b2; rom[3] = v.b3; rom[4] = v.b4;
    endtask

    task automatic check_opts(input vec_t v, input string tag);
        check(p0_cmos === v.e_p0c, {tag, " R3 p0_cmos"}, 32'(p0_cmos), 32'(v.e_p0c));
        check(p1_cmos === v.e_p1c, {tag, " R3 p1_cmos"}, 32'(p1_cmos), 32'(v.e_p1c));
        check(p3_cmos === v.e_p3c, {tag, " R3 p3_cmos"}, 32'(p3_cmos), 32'(v.e_p3c));
        check(p0_pullup === v.e_p0p, {tag, " R4 p0_pullup"}, 32'(p0_pullup), 32'(v.e_p0p));
        check(p7_pullup === v.e_p7p, {tag, " R5 p7_pullup"}, 32'(p7_pullup), 32'(v.e_p7p));
        check(p0_pullup2 === v.e_p0p && p7_pullup2 === v.e_p7p && p0_cmos2 === v.e_p0c,
              {tag, " R3 short instance options"}, 32'({p0_cmos2, p0_pullup2}),
              32'({v.e_p0c, v.e_p0p}));
    endtask

    task automatic check_cleared(input string tag);
        check({cpu_run, load_done, mem_rd, cpu_run2, load_done2, mem_rd2} === 6'b0,
              {tag, " R1 control outputs in reset"},
              32'({cpu_run, load_done, mem_rd}), 32'h0);
        check({p0_cmos, p0_pullup, p1_cmos, p3_cmos, p7_pullup} === 34'b0,
              {tag, " R1 options in reset"},
              32'({p0_cmos, p0_pullup, p1_cmos}), 32'h0);
    endtask

    // Release reset and follow the boot until both instances run.
    task automatic boot(input string tag, input int abort_at);
        int edges = 0, rd_cnt = 0, addr_err = 0, first_rd = -1;
        int done_e = -1, run_e = -1, run2_e = -1, rd_run = 0;
        @(negedge clk);
        rst_n = 1'b1;
        while ((run_e < 0 || run2_e < 0) && edges < 1000) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
            if (mem_rd) begin
                if (first_rd < 0) first_rd = edges;
                if (mem_addr !== 16'hFF00 + 16'(rd_cnt)) addr_err++;
                rd_cnt++;
            end
            if (mem_rd && cpu_run) rd_run++;
            if (load_done && done_e < 0) done_e = edges;
            if (cpu_run && run_e < 0) run_e = edges;
            if (cpu_run2 && run2_e < 0) run2_e = edges;
            if (abort_at > 0 && edges == abort_at) begin
                rst_n = 1'b0;
                #1;
                check_cleared({tag, " R8 mid-load"});
                check(rd_cnt == abort_at, {tag, " R2 reads before abort"}, 32'(rd_cnt),
                      32'(abort_at));
                return;
            end
        end
        check(first_rd == 1, {tag, " R2 first read edge"}, 32'(first_rd), 32'd1);
        check(rd_cnt == 256 && addr_err == 0, {tag, " R2 read count/order"},
              32'(rd_cnt), 32'd256);
        check(done_e == DONE_EDGE, {tag, " R6 load_done edge"}, 32'(done_e), 32'(DONE_EDGE));
        check(run_e == RUN_LONG, {tag, " R7 cpu_run edge (timer bound)"}, 32'(run_e),
              32'(RUN_LONG));
        check(run2_e == RUN_SHORT, {tag, " R7 cpu_run edge (read bound)"}, 32'(run2_e),
              32'(RUN_SHORT));
        check(rd_run == 0, {tag, " R7 no read while running"}, 32'(rd_run), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        int rd_late = 0, run_drop = 0;
        fill_rom(VECS[1], 8'h00);
        repeat (3) @(negedge clk);
        #1;
        check_cleared("initial");

        // Table walk
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            rst_n = 1'b0;
            fill_rom(VECS[v], 8'(v * 37));
            repeat (2) @(negedge clk);
            boot($sformatf("vec%0d", v), 0);
            check_opts(VECS[v], $sformatf("vec%0d", v));
        end

        // R6: options hold while memory changes after loading
        for (int a = 0; a < 256; a++) rom[a] = 8'h00;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (mem_rd || mem_rd2) rd_late++;
            if (!cpu_run || !load_done) run_drop++;
        end
        check(rd_late == 0, "R6 no reads after load", 32'(rd_late), 32'd0);
        check(run_drop == 0, "R7 cpu_run/load_done stay high", 32'(run_drop), 32'd0);
        check_opts(VECS[NV-1], "hold");

        // R8: reset after run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_cleared("R8 after run");

        // R8: reset in mid-load, then a full boot with new contents
        fill_rom(VECS[1], 8'h11);
        repeat (2) @(negedge clk);
        boot("abort", 100);
        fill_rom(VECS[2], 8'h5C);
        repeat (2) @(negedge clk);
        boot("R8 restart", 0);
        check_opts(VECS[2], "R8 restart");

        finish_run();
    end

endmodule